// File: doc/BRIEF.md
# Seven-Bit Odd-Weight-Column Concurrent Error Checker

This block watches seven functional outputs of a protected combinational circuit while it runs. It encodes those seven bits into five check bits of an odd-weight-column single-error-correcting, double-error-detecting code. Every check bit is the XOR of an odd number of data bits. As a result, each check bit is a self-dual function: complementing all seven inputs complements every check bit.

A separate prediction circuit supplies its own five check bits. The block inverts each predicted bit and pairs it with the matching encoder bit, which gives five two-rail pairs. It then folds these pairs into one two-rail result through a chain of two-rail checker cells. A complementary result (01 or 10) means the functional outputs and the prediction agree. An equal result (00 or 11) flags a fault. An error flag repeats that decision as a single bit.

The result pair and the flag can be registered at the output (the default) or left purely combinational. A parameter makes that choice.

Top module: `hsiao_ced_top`

## Requirements
- R1: Check bit i is the XOR of the data bits selected for it. With data bit f1 on func_i[0] through f7 on func_i[6] and check bit gK on pred_i[K-1], the selections are g1 = f1^f2^f3^f5^f6, g2 = f1^f2^f4^f5^f7, g3 = f1^f3^f4^f6^f7, g4 = f2^f3^f4 and g5 = f5^f6^f7. When pred_i equals these bits, err_o is 0.
- R2: Complementing all seven data bits together with all five predicted bits still gives err_o = 0, and rail_o[0] takes the opposite value.
- R3: Flipping any single data bit while the prediction stays fault-free sets err_o to 1.
- R4: Any predicted pattern that differs from the encoded bits in one or more positions sets err_o to 1. This includes every single-bit flip of pred_i.
- R5: When the prediction matches, rail_o[0] equals the XOR of the five check bits and rail_o[1] is its complement.
- R6: err_o is 1 exactly when rail_o[0] equals rail_o[1].
- R7: With REG_OUT = 1, the outputs reflect the inputs sampled at the previous rising clk edge. While rst_n is low, rail_o is 2'b01 and err_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| func_i | input | 7 | Functional outputs of the protected circuit, f1 on bit 0 |
| pred_i | input | 5 | Independently predicted check bits, g1 on bit 0 |
| rail_o | output | 2 | Final two-rail result; complementary means fault-free |
| err_o | output | 1 | High when the two rails are equal |

## Verification
A wrong selection mask, a missing inversion, or a wrong gate in a checker cell changes the result pair. With REG_OUT = 1, this shows at the ports one cycle after the vector that exposes it. Depending on the fault, it appears as a false alarm on a consistent vector, a missed alarm on a corrupted one, or a result rail with the wrong polarity. Sweeping all 128 data words against all 32 predicted patterns puts every mask entry and every cell path in a position where a fault would show. The complement sweep shows whether the self-dual property of the check bits has been preserved.

// File: rtl/hsiao_ced_pkg.sv
package hsiao_ced_pkg;

    localparam int N_DATA = 7;
    localparam int N_CHK  = 5;

    typedef logic [1:0] dual_t;

    typedef struct packed {
        dual_t rail;
        logic  err;
    } ced_out_t;

    // Data-bit selection for each check bit; bit j set means f(j+1) participates.
    function automatic logic [N_DATA-1:0] chk_mask(input int idx);
        logic [N_DATA-1:0] m;
        case (idx)
            0:       m = 7'b011_0111;
            1:       m = 7'b101_1011;
            2:       m = 7'b110_1101;
            3:       m = 7'b000_1110;
            4:       m = 7'b111_0000;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/hsiao_enc.sv
module hsiao_enc
    import hsiao_ced_pkg::*;
#(
    parameter int ND = N_DATA,
    parameter int NC = N_CHK
) (
    input  logic [ND-1:0] data_i,
    output logic [NC-1:0] chk_o
);
    for (genvar i = 0; i < NC; i++) begin : g_chk
        localparam logic [ND-1:0] MASK = chk_mask(i);
        assign chk_o[i] = ^(data_i & MASK);
    end
endmodule

// File: rtl/trc_cell.sv
module trc_cell
    import hsiao_ced_pkg::*;
(
    input  dual_t a_i,
    input  dual_t b_i,
    output dual_t c_o
);
    assign c_o[0] = (a_i[0] & b_i[0]) | (a_i[1] & b_i[1]);
    assign c_o[1] = (a_i[0] & b_i[1]) | (a_i[1] & b_i[0]);
endmodule

// File: rtl/trc_chain.sv
module trc_chain
    import hsiao_ced_pkg::*;
#(
    parameter int NC = N_CHK
) (
    input  logic [NC-1:0] chk_i,
    input  logic [NC-1:0] pred_i,
    output dual_t         out_o
);
    dual_t pair  [NC];
    dual_t stage [NC];

    // Rail 0 carries the encoder bit, rail 1 the inverted prediction.
    for (genvar i = 0; i < NC; i++) begin : g_pair
        assign pair[i] = {~pred_i[i], chk_i[i]};
    end

    assign stage[0] = pair[0];

    for (genvar i = 1; i < NC; i++) begin : g_cell
        trc_cell u_cell (
            .a_i (stage[i-1]),
            .b_i (pair[i]),
            .c_o (stage[i])
        );
    end

    assign out_o = stage[NC-1];
endmodule

// File: rtl/hsiao_ced_top.sv
module hsiao_ced_top
    import hsiao_ced_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_DATA-1:0] func_i,
    input  logic [N_CHK-1:0]  pred_i,
    output logic [1:0]        rail_o,
    output logic              err_o
);
    localparam ced_out_t RESET_VAL = '{rail: 2'b01, err: 1'b0};

    logic [N_CHK-1:0] enc_chk;
    dual_t            fold;
    ced_out_t         out_d;
    ced_out_t         out_q;

    hsiao_enc #(.ND(N_DATA), .NC(N_CHK)) u_enc (
        .data_i (func_i),
        .chk_o  (enc_chk)
    );

    trc_chain #(.NC(N_CHK)) u_chain (
        .chk_i  (enc_chk),
        .pred_i (pred_i),
        .out_o  (fold)
    );

    always_comb begin
        out_d      = RESET_VAL;
        out_d.rail = fold;
        out_d.err  = ~(fold[0] ^ fold[1]);
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_q <= RESET_VAL;
            end else begin
                out_q <= out_d;
            end
        end
    end else begin : g_comb
        assign out_q = out_d;
    end

    assign rail_o = out_q.rail;
    assign err_o  = out_q.err;
endmodule

// File: rtl/hsiao_ced_chk.sv
module hsiao_ced_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] func_i,
    input logic [4:0] pred_i,
    input logic [1:0] rail_o,
    input logic       err_o
);
    logic [4:0] ref_chk;
    logic       match;

    assign ref_chk[0] = func_i[0] ^ func_i[1] ^ func_i[2] ^ func_i[4] ^ func_i[5];
    assign ref_chk[1] = func_i[0] ^ func_i[1] ^ func_i[3] ^ func_i[4] ^ func_i[6];
    assign ref_chk[2] = func_i[0] ^ func_i[2] ^ func_i[3] ^ func_i[5] ^ func_i[6];
    assign ref_chk[3] = func_i[1] ^ func_i[2] ^ func_i[3];
    assign ref_chk[4] = func_i[4] ^ func_i[5] ^ func_i[6];
    assign match      = (ref_chk == pred_i);

    if (REG_OUT) begin : g_seq
        p_clean_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
            match |=> !err_o);
        p_mismatch_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !match |=> err_o);
        p_rail_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
            match |=> (rail_o[0] == $past(^pred_i)));
    end else begin : g_comb
        p_clean_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
            match |-> !err_o);
        p_mismatch_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !match |-> err_o);
        p_rail_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
            match |-> (rail_o[0] == ^pred_i));
    end

    p_flag_rails_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !err_o |-> (rail_o[0] != rail_o[1]));
endmodule

bind hsiao_ced_top hsiao_ced_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .func_i (func_i),
    .pred_i (pred_i),
    .rail_o (rail_o),
    .err_o  (err_o)
);

// File: tb/sim_hsiao_ced_top.sv
module sim_hsiao_ced_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] func_i = '0;
    logic [4:0] pred_i = '0;
    logic [1:0] rail_o;
    logic       err_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    hsiao_ced_top #(.REG_OUT(1'b1)) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .func_i (func_i),
        .pred_i (pred_i),
        .rail_o (rail_o),
        .err_o  (err_o)
    );

    function automatic logic [4:0] encode(input logic [6:0] f);
        logic [6:0] sel [5];
        logic [4:0] g;
        sel[0] = 7'h37; sel[1] = 7'h5B; sel[2] = 7'h6D; sel[3] = 7'h0E; sel[4] = 7'h70;
        for (int i = 0; i < 5; i++) g[i] = ^(f & sel[i]);
        return g;
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s f=%h p=%h act={rail=%b,err=%b} exp={rail=%b,err=%b}",
                     req, func_i, pred_i, act[2:1], act[0], exp[2:1], exp[0]);
        end
    endtask

    task automatic apply(input logic [6:0] f, input logic [4:0] p);
        @(negedge clk);
        func_i = f;
        pred_i = p;
        @(negedge clk);
    endtask

    initial begin
        logic [4:0] g;
        logic       par;
        repeat (3) @(negedge clk);
        check("R7 reset", {rail_o, err_o}, {2'b01, 1'b0});
        rst_n = 1'b1;

        // R1, R4, R5, R6: every data word against every predicted pattern
        for (int f = 0; f < 128; f++) begin
            for (int p = 0; p < 32; p++) begin
                g = encode(7'(f));
                apply(7'(f), 5'(p));
                if (5'(p) == g) begin
                    par = ^g;
                    check("R1/R5/R6 clean", {rail_o, err_o}, {~par, par, 1'b0});
                end else begin
                    check("R4/R6 predicted mismatch", {1'b0, 1'b0, err_o}, 3'b001);
                    check("R6 equal rails", {1'b0, 1'b0, rail_o[0] ^ rail_o[1]}, 3'b000);
                end
            end
        end

        // R3: single data-bit flips with a fault-free prediction
        for (int f = 0; f < 128; f++) begin
            for (int b = 0; b < 7; b++) begin
                apply(7'(f) ^ (7'd1 << b), encode(7'(f)));
                check("R3 data flip", {1'b0, 1'b0, err_o}, 3'b001);
            end
        end

        // R2: complemented data and complemented prediction
        for (int f = 0; f < 128; f++) begin
            g = encode(7'(f));
            apply(~7'(f), ~g);
            par = ~(^g);
            check("R2 self-dual", {rail_o, err_o}, {~par, par, 1'b0});
        end

        // R7: one-cycle latency, old result held until the clock edge
        apply(7'h00, 5'h1F);
        @(negedge clk);
        func_i = 7'h00;
        pred_i = encode(7'h00);
        #1;
        check("R7 latency hold", {1'b0, 1'b0, err_o}, 3'b001);
        @(negedge clk);
        check("R7 latency update", {1'b0, 1'b0, err_o}, 3'b000);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog act=running exp=finished");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule